// File: doc/BRIEF.md
# Palette Entry Converter

This block takes the colour-table words that a display fetch engine reads from memory and turns each one into a uniform colour value. Each value has 8-bit red, green and blue components and a transparency bit. The results are written, one per cycle, into a palette table that sits beside the block. A start strobe sets up a conversion. On that strobe the block samples the indexed colour depth, the packed entry format and a monochrome mode bit, and it holds those values until the conversion ends. The raw words then arrive on a valid/ready stream. The block raises busy for the length of the conversion and pulses done once the final table entry has been written.

Four packed layouts are supported. One is a 16-bit 5-6-5 layout that carries two entries per stream word. The other three are 32-bit layouts with 5-6-5, 6-6-6 or 8-8-8 components and a transparency flag in bit 24. Monochrome mode sends the low byte of an entry to all three components. The block also watches the live format select. When that select no longer matches the format used for the last conversion, the block flags the table as stale so the owner can run the conversion again.

Back-pressure rules: a word moves only on a cycle where in_valid and in_ready are both high. in_ready is never high while the block is idle. In the 16-bit layout, in_ready also drops for one cycle after each accepted word while the upper entry is written. The source may hold in_valid low for any number of cycles without losing data.

Top module: `pal_entry_conv`

## Requirements
- R1: While reset is held and right after it, busy, done, wr_en, in_ready and fmt_stale are all low.
- R2: The depth code set at start gives the entry count: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. Code 0 writes nothing, leaves busy low and pulses done in the cycle after the start strobe.
- R3: Format code 0 takes 16-bit entries, two per word, with bits [15:0] first and bits [31:16] second. Red is {e[15:11],000}, green is {e[10:5],00} and blue is {e[4:0],000}. in_ready is low in the cycle after each word is accepted.
- R4: Format code 1 gives red {w[23:19],000}, green {w[15:10],00} and blue {w[7:3],000}.
- R5: Format code 2 gives red {w[23:18],00}, green {w[15:10],00} and blue {w[7:2],00}.
- R6: Format code 3 gives red w[23:16], green w[15:8] and blue w[7:0].
- R7: The transparency bit, which is bit 24 of wr_data, equals w[24] for format codes 1 to 3 and is always 0 for format code 0.
- R8: With monochrome mode set, red, green and blue all equal the low 8 bits of the entry, whatever the format.
- R9: Table addresses start at 0 and rise by one with each written entry. wr_data is packed {transparency, red[7:0], green[7:0], blue[7:0]}.
- R10: A word is taken only when in_valid and in_ready are both high. in_ready is low while the block is idle. When in_valid is held low, nothing is written.
- R11: busy is high from the cycle after start until the final entry is written. done is high for exactly one cycle, the same cycle in which the final wr_en is high.
- R12: A start strobe that arrives while busy is ignored. Changes to format, mode or depth during a conversion have no effect on that conversion.
- R13: fmt_stale is high when the block is idle, at least one conversion has been started since reset, and the live format select differs from the format captured for the last conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (sampled only while idle) |
| depth_sel | input | 2 | Indexed depth code: 0 none, 1/2/3 give 4/16/256 entries |
| fmt_sel | input | 2 | Packed entry format code 0..3 |
| mono_sel | input | 1 | Monochrome mode: low byte onto all components |
| in_valid | input | 1 | Raw palette word valid |
| in_ready | output | 1 | Block can take a raw word |
| in_data | input | 32 | Raw palette word |
| wr_en | output | 1 | Palette table write strobe |
| wr_addr | output | 8 | Palette table index |
| wr_data | output | 25 | {transparency, red, green, blue} |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse with the final write |
| fmt_stale | output | 1 | Table was built with a different format than selected now |

## Verification
The bench targets the 16-bit layout. There it checks that the lower half of a word is written before the upper half and that in_ready drops while the upper half drains; a design that swapped the halves or kept accepting words would write the entries out of order or lose half of them. It runs a start strobe during a conversion, with a new format held on the pins, to catch a design that restarts or re-samples its settings partway through. It also checks the empty depth code, where a design that still raised busy would hang. Finally, it confirms that done lines up with the 4th, 16th and 256th write and that the transparency bit is kept clear in format 0, which catches off-by-one counting and alpha leaking through from the upper halfword.

// File: rtl/pal_conv_pkg.sv
package pal_conv_pkg;

  typedef enum logic [1:0] {
    FMT_HALF565 = 2'd0,
    FMT_WORD565 = 2'd1,
    FMT_WORD666 = 2'd2,
    FMT_WORD888 = 2'd3
  } pal_fmt_e;

  typedef struct packed {
    logic       alpha;
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } pal_rgba_t;

  // Number of table entries for a depth code; 0 means non-indexed.
  function automatic int unsigned pal_entry_count(input logic [1:0] depth);
    case (depth)
      2'd1:    return 4;
      2'd2:    return 16;
      2'd3:    return 256;
      default: return 0;
    endcase
  endfunction

  function automatic pal_rgba_t pal_convert(input pal_fmt_e fmt, input logic mono,
                                            input logic [31:0] raw);
    pal_rgba_t o;
    o.alpha = (fmt == FMT_HALF565) ? 1'b0 : raw[24];
    case (fmt)
      FMT_HALF565: begin
        o.red   = {raw[15:11], 3'b000};
        o.green = {raw[10:5], 2'b00};
        o.blue  = {raw[4:0], 3'b000};
      end
      FMT_WORD565: begin
        o.red   = {raw[23:19], 3'b000};
        o.green = {raw[15:10], 2'b00};
        o.blue  = {raw[7:3], 3'b000};
      end
      FMT_WORD666: begin
        o.red   = {raw[23:18], 2'b00};
        o.green = {raw[15:10], 2'b00};
        o.blue  = {raw[7:2], 2'b00};
      end
      default: begin
        o.red   = raw[23:16];
        o.green = raw[15:8];
        o.blue  = raw[7:0];
      end
    endcase
    if (mono) begin
      o.red   = raw[7:0];
      o.green = raw[7:0];
      o.blue  = raw[7:0];
    end
    return o;
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_conv_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       depth_sel,
  input  pal_fmt_e         fmt_sel,
  input  logic             mono_sel,
  input  logic             ent_fire,
  output logic             busy,
  output logic             done,
  output pal_fmt_e         cap_fmt,
  output logic             cap_mono,
  output logic [IDX_W-1:0] ent_idx,
  output logic             fmt_stale
);
  localparam int CNT_W = IDX_W + 1;

  logic             busy_q, done_q, mono_q, seen_q;
  pal_fmt_e         fmt_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [CNT_W-1:0] start_cnt;

  assign start_cnt = CNT_W'(pal_entry_count(depth_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mono_q <= 1'b0;
      seen_q <= 1'b0;
      fmt_q  <= FMT_HALF565;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        fmt_q  <= fmt_sel;
        mono_q <= mono_sel;
        seen_q <= 1'b1;
        idx_q  <= '0;
        if (start_cnt == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          last_q <= IDX_W'(start_cnt - 1'b1);
        end
      end else if (busy_q && ent_fire) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign cap_fmt   = fmt_q;
  assign cap_mono  = mono_q;
  assign ent_idx   = idx_q;
  assign fmt_stale = seen_q && !busy_q && (fmt_sel != fmt_q);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cap_fmt) && $stable(cap_mono))); // R12
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q)); // R2

endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
  import pal_conv_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              half_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              ent_valid,
  output logic [WORD_W-1:0] ent_raw
);
  localparam int HALF_W = WORD_W / 2;

  logic              hold_q;
  logic [HALF_W-1:0] upper_q;
  logic              accept;

  assign in_ready = busy && !hold_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      upper_q <= '0;
    end else if (!busy || hold_q) begin
      hold_q <= 1'b0;
    end else if (accept && half_mode) begin
      hold_q  <= 1'b1;
      upper_q <= in_data[WORD_W-1:HALF_W];
    end
  end

  always_comb begin
    ent_valid = hold_q || accept;
    if (hold_q)         ent_raw = WORD_W'(upper_q);
    else if (half_mode) ent_raw = WORD_W'(in_data[HALF_W-1:0]);
    else                ent_raw = in_data;
  end

  AST_UPPER_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> !hold_q); // R3
  AST_HOLD_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> ($past(in_valid) && $past(busy))); // R10

endmodule

// File: rtl/pal_wr.sv
module pal_wr
  import pal_conv_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_valid,
  input  logic [31:0]      ent_raw,
  input  logic [IDX_W-1:0] ent_idx,
  input  pal_fmt_e         fmt,
  input  logic             mono,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output pal_rgba_t        wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= ent_valid;
      if (ent_valid) begin
        wr_addr <= ent_idx;
        wr_data <= pal_convert(fmt, mono, ent_raw);
      end
    end
  end

  AST_FMT0_NO_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fmt) == FMT_HALF565) |-> !wr_data.alpha); // R7
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R9

endmodule

// File: rtl/pal_entry_conv.sv
module pal_entry_conv
  import pal_conv_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        depth_sel,
  input  logic [1:0]        fmt_sel,
  input  logic              mono_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [24:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              fmt_stale
);
  pal_fmt_e         cap_fmt;
  logic             cap_mono;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_valid;
  logic [31:0]      ent_raw;
  pal_rgba_t        wr_rgba;

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .depth_sel(depth_sel),
    .fmt_sel(pal_fmt_e'(fmt_sel)), .mono_sel(mono_sel), .ent_fire(ent_valid),
    .busy(busy), .done(done), .cap_fmt(cap_fmt), .cap_mono(cap_mono),
    .ent_idx(ent_idx), .fmt_stale(fmt_stale)
  );

  pal_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .half_mode(cap_fmt == FMT_HALF565), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data),
    .ent_valid(ent_valid), .ent_raw(ent_raw)
  );

  pal_wr #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_raw(ent_raw),
    .ent_idx(ent_idx), .fmt(cap_fmt), .mono(cap_mono),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_rgba)
  );

  assign wr_data = wr_rgba;

  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy ^ done)); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !wr_en); // R10
  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R10

endmodule

// File: tb/pal_entry_conv_bench.sv
module pal_entry_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  depth_sel = 2'd0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        mono_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [24:0] wr_data;
  logic        busy, done, fmt_stale;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  pal_entry_conv u_pal_entry_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .depth_sel(depth_sel),
    .fmt_sel(fmt_sel), .mono_sel(mono_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .fmt_stale(fmt_stale)
  );

  // write monitor, sampled at the falling edge
  int          mon_n = 0;
  logic [7:0]  mon_addr [256];
  logic [24:0] mon_data [256];
  int          done_cnt = 0;
  int          done_at  = -1;
  logic [31:0] exp_raw [256];

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (mon_n < 256) begin
        mon_addr[mon_n] = wr_addr;
        mon_data[mon_n] = wr_data;
      end
      mon_n = mon_n + 1;
    end
    if (rst_n && done) begin
      done_cnt = done_cnt + 1;
      done_at  = wr_en ? mon_n : -1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] model(input int fmt, input bit mono, input logic [31:0] e);
    logic [7:0] r, g, b;
    logic a;
    a = (fmt == 0) ? 1'b0 : e[24];
    if (fmt == 0) begin
      r = (e[15:0] >> 11) << 3; g = ((e[15:0] >> 5) & 16'h3f) << 2; b = (e[15:0] & 16'h1f) << 3;
    end else if (fmt == 1) begin
      r = ((e >> 19) & 32'h1f) << 3; g = ((e >> 10) & 32'h3f) << 2; b = ((e >> 3) & 32'h1f) << 3;
    end else if (fmt == 2) begin
      r = ((e >> 18) & 32'h3f) << 2; g = ((e >> 10) & 32'h3f) << 2; b = ((e >> 2) & 32'h3f) << 2;
    end else begin
      r = e[23:16]; g = e[15:8]; b = e[7:0];
    end
    if (mono) begin r = e[7:0]; g = e[7:0]; b = e[7:0]; end
    return {a, r, g, b};
  endfunction

  function automatic int count_of(input int depth);
    return (depth == 1) ? 4 : (depth == 2) ? 16 : (depth == 3) ? 256 : 0;
  endfunction

  task automatic clear_mon();
    mon_n = 0; done_cnt = 0; done_at = -1;
  endtask

  task automatic pulse_start(input int fmt, input bit mono, input int depth);
    @(negedge clk);
    fmt_sel = 2'(fmt); mono_sel = mono; depth_sel = 2'(depth); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [31:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic make_entries(input int fmt, input int n, input int salt);
    logic [31:0] s;
    s = 32'h1234_5678 ^ salt;
    for (int i = 0; i < n; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      exp_raw[i] = (fmt == 0) ? {16'h0, s[31:16]} : s;
    end
  endtask

  task automatic stream(input int fmt, input int n, input int gap);
    if (fmt == 0) begin
      for (int w = 0; w < n / 2; w++) begin
        send({exp_raw[2*w+1][15:0], exp_raw[2*w][15:0]});
        for (int k = 0; k < gap; k++) @(negedge clk);
      end
    end else begin
      for (int w = 0; w < n; w++) begin
        send(exp_raw[w]);
        for (int k = 0; k < gap; k++) @(negedge clk);
      end
    end
  endtask

  task automatic verify(input int fmt, input bit mono, input int n, input string req);
    for (int k = 0; k < 4; k++) @(negedge clk);
    check(mon_n == n, "R2 entry count", mon_n, n);
    check(done_cnt == 1, "R11 done pulses", done_cnt, 1);
    check(done_at == n, "R11 done with final write", done_at, n);
    check(busy == 1'b0, "R11 busy low after", busy, 0);
    for (int i = 0; i < n && i < mon_n; i++) begin
      check(mon_addr[i] == 8'(i), "R9 address order", mon_addr[i], i);
      check(mon_data[i] == model(fmt, mono, exp_raw[i]), req, mon_data[i],
            model(fmt, mono, exp_raw[i]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({busy, done, wr_en, in_ready, fmt_stale} == 5'b0, "R1 in reset",
          {busy, done, wr_en, in_ready, fmt_stale}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, wr_en, in_ready, fmt_stale} == 5'b0, "R1 after reset",
          {busy, done, wr_en, in_ready, fmt_stale}, 0);
  endtask

  task automatic t_half565();
    clear_mon();
    make_entries(0, 4, 11);
    exp_raw[1] = 32'h0000_FFFF;
    pulse_start(0, 1'b0, 1);
    send({exp_raw[1][15:0], exp_raw[0][15:0]});
    check(in_ready == 1'b0, "R3 ready drops for upper half", in_ready, 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R3 ready back after drain", in_ready, 1);
    send({exp_raw[3][15:0], exp_raw[2][15:0]});
    verify(0, 1'b0, 4, "R3 R7 format 0 lower half first");
  endtask

  task automatic t_word(input int fmt, input int depth, input int gap, input string req);
    int n;
    n = count_of(depth);
    clear_mon();
    make_entries(fmt, n, fmt * 7 + depth);
    exp_raw[0][24] = 1'b1;
    exp_raw[1][24] = 1'b0;
    pulse_start(fmt, 1'b0, depth);
    stream(fmt, n, gap);
    verify(fmt, 1'b0, n, req);
  endtask

  task automatic t_mono(input int fmt);
    clear_mon();
    make_entries(fmt, 16, 99 + fmt);
    pulse_start(fmt, 1'b1, 2);
    stream(fmt, 16, 0);
    verify(fmt, 1'b1, 16, "R8 monochrome");
  endtask

  task automatic t_empty();
    clear_mon();
    @(negedge clk);
    fmt_sel = 2'd2; depth_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R2 empty depth done next cycle", done, 1);
    check(busy == 1'b0, "R2 empty depth stays idle", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done single cycle", done, 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check(mon_n == 0, "R2 empty depth writes nothing", mon_n, 0);
  endtask

  task automatic t_stall_and_restart();
    clear_mon();
    make_entries(1, 4, 5);
    pulse_start(1, 1'b0, 1);
    check(in_ready == 1'b1, "R10 ready while busy", in_ready, 1);
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(mon_n == 0, "R10 no write without valid", mon_n, 0);
    check(busy == 1'b1, "R11 busy while waiting", busy, 1);
    send(exp_raw[0]);
    send(exp_raw[1]);
    // start with other settings mid-conversion: must be ignored
    fmt_sel = 2'd3; mono_sel = 1'b1; depth_sel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(fmt_stale == 1'b0, "R13 not stale while busy", fmt_stale, 0);
    send(exp_raw[2]);
    send(exp_raw[3]);
    verify(1, 1'b0, 4, "R12 settings held through conversion");
    #1;
    check(fmt_stale == 1'b1, "R13 stale after select change", fmt_stale, 1);
    fmt_sel = 2'd1;
    #1;
    check(fmt_stale == 1'b0, "R13 clear when select matches", fmt_stale, 0);
    mono_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_half565();
    t_word(1, 2, 1, "R4 R7 format 1");
    t_word(2, 1, 0, "R5 R7 format 2");
    t_word(3, 3, 0, "R6 R7 format 3");
    t_word(0, 3, 0, "R3 format 0 full table");
    t_mono(0);
    t_mono(3);
    t_empty();
    t_stall_and_restart();
    summary();
  end

endmodule